// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block is a clocked sequencer for one synchronous buck phase. It takes a pulse-width command that arrives as three comparator outputs (command high, command low, command in the middle window). From that command it produces two gate enables, one for the high-side switch and one for the low-side switch. It watches feedback comparators to decide when the dead time between the two switches can end: the low gate having discharged, the high gate having discharged, and the switch node having fallen. A cycle-counted timeout stands in for a switch-node reading that never arrives.

When the command sits in the middle window for a holdoff time, the block parks both switches off. In light-load mode it emulates a diode: the low-side switch is opened when the inductor current crosses zero, but never before a minimum on-time has run. A power-good input gates all activity.

Every asynchronous input is resynchronised with two flops. An input change therefore reaches the gate outputs three clock edges after it is applied, plus whatever wait the sequence itself adds. All delays are parameters counted in clock cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: After reset, and for as long as the synchronised power-good input is low, both gate enables are low. When power-good returns, a high command sequences the high gate on through the normal dead time.
- R2: When the command goes high, the low gate drops three cycles later. The high gate rises only once the low-gate-discharged flag is seen and the low-side exit has lasted at least BLANK_CYC cycles. With the flag already present, both gates are off for exactly BLANK_CYC cycles. Without the flag, the high gate never rises.
- R3: When the command goes low, the high gate drops three cycles later. The low gate rises one cycle after that if the switch-node-low flag is present. If that flag arrives later, the low gate rises three cycles after it.
- R4: In the falling dead time, with switch-node-low absent and the high-gate-discharged flag present, the low gate rises BACKUP_CYC cycles after the high gate dropped. With both flags absent, the low gate stays off.
- R5: A command held in the middle window turns both gates off HOLD_CYC+3 cycles after it is applied. Before that point, the gate that was on stays on.
- R6: Shutdown ends as soon as the command leaves the middle window. A low command restores the low gate three cycles after it is applied. A high command restores the high gate through the R2 dead time.
- R7: In light-load mode, the zero-crossing flag opens the low gate once it has been on for MIN_ON_CYC cycles. The low gate then stays off while the command remains low. Leaving light-load mode with the command low turns the low gate back on, and the zero-crossing flag is ignored outside light-load mode.
- R8: In light-load mode, a middle-window command does not open the low gate before its MIN_ON_CYC on-time has run, even after the holdoff has expired.
- R9: The two gate enables are never high in the same cycle.
- R10: A new command edge during a dead-time wait redirects the sequence toward the new command. The gate that must open is opened first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_hi_i | input | 1 | Command comparator: above the upper threshold |
| pwm_lo_i | input | 1 | Command comparator: below the lower threshold |
| pwm_mid_i | input | 1 | Command comparator: inside the middle window |
| lg_low_i | input | 1 | Low gate voltage below its turn-on threshold |
| hg_low_i | input | 1 | High gate-to-source voltage below its threshold |
| sw_low_i | input | 1 | Switch node below its low threshold |
| zc_i | input | 1 | Inductor current has reached zero |
| light_load_i | input | 1 | Light-load (diode emulation) mode select |
| por_ok_i | input | 1 | Supply good; low holds both gates off |
| hg_en_o | output | 1 | High-side gate enable |
| lg_en_o | output | 1 | Low-side gate enable |

## Verification
The bench targets the exact cycle at which each dead time ends. A sequencer that ignores the blanking count, or that trusts a stale low-gate flag, turns the high gate on early. One that skips the backup timeout leaves the phase stuck with both switches open. It also redirects commands mid-wait; a design that finished the stale sequence first would briefly drive the wrong gate.

On the light-load side, it pits the holdoff against the longer minimum on-time and checks that zero-crossing is ignored in continuous mode. A design that lets shutdown or zero-crossing cut the low gate short shows its low enable falling many cycles early.

// File: rtl/hb_pkg.sv
// Package: shared state encoding for the half-bridge gate sequencer.
// Assumes: one state register; the gate enables are decoded from it.
package hb_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,  // power-up idle, both gates open
        ST_LS_ON   = 3'd1,  // low-side switch conducting
        ST_DT_RISE = 3'd2,  // dead time before high side
        ST_HS_ON   = 3'd3,  // high-side switch conducting
        ST_DT_FALL = 3'd4,  // dead time before low side
        ST_DE_IDLE = 3'd5,  // diode emulation, low side released
        ST_SHUT    = 3'd6   // mid-window shutdown
    } hb_state_e;

    // Index of each input inside the synchronised bundle.
    localparam int IDX_PWM_HI = 0;
    localparam int IDX_PWM_LO = 1;
    localparam int IDX_PWM_MID = 2;
    localparam int IDX_LG_LOW = 3;
    localparam int IDX_HG_LOW = 4;
    localparam int IDX_SW_LOW = 5;
    localparam int IDX_ZC = 6;
    localparam int IDX_LIGHT = 7;
    localparam int IDX_POR = 8;
    localparam int NUM_INPUTS = 9;

endpackage

// File: rtl/hb_sync.sv
// Module: two-flop synchroniser for a bundle of asynchronous levels.
// Assumes: each bit is an independent slow level; bits are not coherent
// with each other. Reset clears both stages so everything reads inactive.
module hb_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two register stages per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/hb_tristate_timer.sv
// Module: holdoff timer for the middle-window command.
// Assumes: mid_i is already synchronised. shut_o rises after mid_i has
// been high for HOLD_CYC consecutive cycles and drops in the same cycle
// mid_i drops, so release is immediate.
module hb_tristate_timer #(
    parameter int HOLD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mid_i,
    output logic shut_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD_CYC);

    logic [CW-1:0] dwell_q;

    // Count consecutive mid-window cycles, saturating at the holdoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else if (!mid_i) begin
            dwell_q <= '0;
        end else if (dwell_q != HOLD_C) begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    assign shut_o = mid_i && (dwell_q == HOLD_C);

    // R5: shutdown can only begin after the window was held the cycle before.
    a_r5_shut_needs_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_o) |-> $past(mid_i));

endmodule

// File: rtl/hb_gate_fsm.sv
// Module: gate sequencing state machine with adaptive dead time.
// Assumes: every input is synchronised. One shared counter measures the
// time spent in the current state. In the rising dead time it provides
// blanking, in the falling dead time it is the backup timer (it counts
// only while the high-gate flag holds), and in the low-side state it is
// the diode-emulation minimum on-time.
module hb_gate_fsm
    import hb_pkg::*;
#(
    parameter int BLANK_CYC  = 3,
    parameter int BACKUP_CYC = 4,
    parameter int MIN_ON_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic shut,
    input  logic lg_low,
    input  logic hg_low,
    input  logic sw_low,
    input  logic zc,
    input  logic light_load,
    input  logic por_ok,
    output logic hg_en_o,
    output logic lg_en_o
);

    localparam int LIM0 = (BLANK_CYC > BACKUP_CYC) ? BLANK_CYC : BACKUP_CYC;
    localparam int LIM = (LIM0 > MIN_ON_CYC) ? LIM0 : MIN_ON_CYC;
    localparam int CW = $clog2(LIM + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIM);
    localparam logic [CW-1:0] BLANK_C = CW'(BLANK_CYC);
    localparam logic [CW-1:0] BACKUP_C = CW'(BACKUP_CYC);
    localparam logic [CW-1:0] MIN_ON_C = CW'(MIN_ON_CYC);

    hb_state_e     state_q;
    hb_state_e     state_d;
    logic [CW-1:0] cnt_q;
    logic          min_on_met;

    assign min_on_met = (cnt_q >= MIN_ON_C);

    // Next-state selection; the gate that must open is always left first.
    always_comb begin
        state_d = state_q;
        if (!por_ok) begin
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF: begin
                    if (shut)        state_d = ST_SHUT;
                    else if (pwm_hi) state_d = ST_DT_RISE;
                    else if (pwm_lo) state_d = ST_LS_ON;
                end
                ST_LS_ON: begin
                    if (pwm_hi) begin
                        state_d = ST_DT_RISE;
                    end else if (light_load) begin
                        if (min_on_met && shut)    state_d = ST_SHUT;
                        else if (min_on_met && zc) state_d = ST_DE_IDLE;
                    end else if (shut) begin
                        state_d = ST_SHUT;
                    end
                end
                ST_DT_RISE: begin
                    if (pwm_lo)                            state_d = ST_LS_ON;
                    else if (shut)                         state_d = ST_SHUT;
                    else if (lg_low && cnt_q >= BLANK_C)   state_d = ST_HS_ON;
                end
                ST_HS_ON: begin
                    if (pwm_lo)    state_d = ST_DT_FALL;
                    else if (shut) state_d = ST_SHUT;
                end
                ST_DT_FALL: begin
                    if (pwm_hi)                          state_d = ST_DT_RISE;
                    else if (shut)                       state_d = ST_SHUT;
                    else if (sw_low || cnt_q >= BACKUP_C) state_d = ST_LS_ON;
                end
                ST_DE_IDLE: begin
                    if (pwm_hi)                     state_d = ST_DT_RISE;
                    else if (shut)                  state_d = ST_SHUT;
                    else if (!light_load && pwm_lo) state_d = ST_LS_ON;
                end
                ST_SHUT: begin
                    if (!shut && pwm_hi)      state_d = ST_DT_RISE;
                    else if (!shut && pwm_lo) state_d = ST_LS_ON;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Dwell counter: 1 on entry, saturating; held at 0 in the falling
    // dead time while the high-gate flag is absent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= CW'(1);
        end else if (state_q == ST_DT_FALL && !hg_low) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hg_en_o = (state_q == ST_HS_ON);
    assign lg_en_o = (state_q == ST_LS_ON);

    // R9: never both switches on together.
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hg_en_o && lg_en_o));

    // R2: the high gate rises only after the low gate was off and discharged.
    a_r2_hs_after_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hg_en_o) |-> (lg_low && $past(!lg_en_o)));

    // R3: the low gate rises only after the high gate was already off.
    a_r3_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lg_en_o) |-> $past(!hg_en_o));

    // R1: supply not good forces both gates off on the next cycle.
    a_r1_por_off: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (!hg_en_o && !lg_en_o));

    // R5: expired holdoff outside light-load mode opens both gates.
    a_r5_shut_off: assert property (@(posedge clk) disable iff (!rst_n)
        (shut && !light_load && por_ok) |=> (!hg_en_o && !lg_en_o));

    // R8: in light-load mode the low gate keeps its minimum on-time.
    a_r8_min_on: assert property (@(posedge clk) disable iff (!rst_n)
        (light_load && lg_en_o && !min_on_met && !pwm_hi && por_ok) |=> lg_en_o);

endmodule

// File: rtl/hb_gate_seq.sv
// Module: top of the half-bridge gate sequencer.
// Assumes: all inputs are asynchronous comparator levels. They pass a
// two-flop synchroniser, so input-to-output latency is three clock edges
// plus any dead time or holdoff the sequence adds.
module hb_gate_seq
    import hb_pkg::*;
#(
    parameter int BLANK_CYC  = 3,
    parameter int BACKUP_CYC = 4,
    parameter int HOLD_CYC   = 20,
    parameter int MIN_ON_CYC = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi_i,
    input  logic pwm_lo_i,
    input  logic pwm_mid_i,
    input  logic lg_low_i,
    input  logic hg_low_i,
    input  logic sw_low_i,
    input  logic zc_i,
    input  logic light_load_i,
    input  logic por_ok_i,
    output logic hg_en_o,
    output logic lg_en_o
);

    logic [NUM_INPUTS-1:0] raw;
    logic [NUM_INPUTS-1:0] syn;
    logic                  shut;

    // Gather the asynchronous inputs into one bundle.
    always_comb begin
        raw              = '0;
        raw[IDX_PWM_HI]  = pwm_hi_i;
        raw[IDX_PWM_LO]  = pwm_lo_i;
        raw[IDX_PWM_MID] = pwm_mid_i;
        raw[IDX_LG_LOW]  = lg_low_i;
        raw[IDX_HG_LOW]  = hg_low_i;
        raw[IDX_SW_LOW]  = sw_low_i;
        raw[IDX_ZC]      = zc_i;
        raw[IDX_LIGHT]   = light_load_i;
        raw[IDX_POR]     = por_ok_i;
    end

    hb_sync #(.WIDTH(NUM_INPUTS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (syn)
    );

    hb_tristate_timer #(.HOLD_CYC(HOLD_CYC)) u_tri (
        .clk    (clk),
        .rst_n  (rst_n),
        .mid_i  (syn[IDX_PWM_MID]),
        .shut_o (shut)
    );

    hb_gate_fsm #(
        .BLANK_CYC  (BLANK_CYC),
        .BACKUP_CYC (BACKUP_CYC),
        .MIN_ON_CYC (MIN_ON_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_hi     (syn[IDX_PWM_HI]),
        .pwm_lo     (syn[IDX_PWM_LO]),
        .shut       (shut),
        .lg_low     (syn[IDX_LG_LOW]),
        .hg_low     (syn[IDX_HG_LOW]),
        .sw_low     (syn[IDX_SW_LOW]),
        .zc         (syn[IDX_ZC]),
        .light_load (syn[IDX_LIGHT]),
        .por_ok     (syn[IDX_POR]),
        .hg_en_o    (hg_en_o),
        .lg_en_o    (lg_en_o)
    );

endmodule

// File: tb/hb_gate_seq_tb.sv
// Scoreboard bench: the driver pushes expected gate states with a due
// cycle; a monitor on the falling edge pops and compares them.
module hb_gate_seq_tb;

    localparam int BLANK = 3;
    localparam int BACKUP = 4;
    localparam int HOLD = 5;
    localparam int MINON = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_hi = 0, pwm_lo = 0, pwm_mid = 0;
    logic lg_low = 0, hg_low = 0, sw_low = 0, zc = 0, light = 0, por = 0;
    logic hg_en, lg_en;

    typedef struct {
        int    due;
        bit    hg;
        bit    lg;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t item;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   overlap = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    hb_gate_seq #(
        .BLANK_CYC(BLANK), .BACKUP_CYC(BACKUP),
        .HOLD_CYC(HOLD), .MIN_ON_CYC(MINON)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo), .pwm_mid_i(pwm_mid),
        .lg_low_i(lg_low), .hg_low_i(hg_low), .sw_low_i(sw_low),
        .zc_i(zc), .light_load_i(light), .por_ok_i(por),
        .hg_en_o(hg_en), .lg_en_o(lg_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation that has fallen due.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item = q.pop_front();
            checks++;
            if (item.due != cyc || hg_en !== item.hg || lg_en !== item.lg) begin
                errors++;
                $display("FAIL %s cyc %0d: got hg=%b lg=%b, expected hg=%b lg=%b (due %0d)",
                         item.tag, cyc, hg_en, lg_en, item.hg, item.lg, item.due);
            end
        end
        if (rst_n && hg_en && lg_en) overlap++;
    end

    task automatic expect_at(input int off, input bit hg, input bit lg, input string tag);
        exp_t e;
        e.due = cyc + off;
        e.hg = hg;
        e.lg = lg;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input bit h, input bit l, input bit m);
        pwm_hi = h;
        pwm_lo = l;
        pwm_mid = m;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got a hung run, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        expect_at(1, 0, 0, "R1 reset state");
        step(2);

        // R1: low command while the supply is not good keeps both off.
        cmd(0, 1, 0);
        expect_at(4, 0, 0, "R1 por low");
        step(6);
        por = 1;
        expect_at(2, 0, 0, "R1 por rising latency");
        expect_at(3, 0, 1, "R1 por good low side");
        step(5);

        // R2: rising command, low gate flag absent -> wait.
        cmd(1, 0, 0); lg_low = 0;
        expect_at(2, 0, 1, "R2 latency");
        expect_at(3, 0, 0, "R2 low gate off first");
        expect_at(8, 0, 0, "R2 waits for low gate flag");
        step(9);
        lg_low = 1;
        expect_at(2, 0, 0, "R2 flag latency");
        expect_at(3, 1, 0, "R2 high gate on after flag");
        step(5);

        // R3: falling command with switch node already low.
        cmd(0, 1, 0); sw_low = 1; hg_low = 0;
        expect_at(2, 1, 0, "R3 latency");
        expect_at(3, 0, 0, "R3 high gate off first");
        expect_at(4, 0, 1, "R3 low gate after switch node low");
        step(6);

        // R2: blanking with flag already present.
        cmd(1, 0, 0);
        expect_at(3, 0, 0, "R2 blank start");
        expect_at(5, 0, 0, "R2 blank end");
        expect_at(6, 1, 0, "R2 high gate after blank");
        step(8);

        // R4: backup timeout with high-gate flag only.
        cmd(0, 1, 0); sw_low = 0; hg_low = 1;
        expect_at(3, 0, 0, "R4 backup start");
        expect_at(6, 0, 0, "R4 backup still waiting");
        expect_at(7, 0, 1, "R4 backup expiry");
        step(9);

        // R4: neither flag -> low gate stays off; R3 late switch node.
        cmd(1, 0, 0);
        expect_at(6, 1, 0, "R2 high gate");
        step(8);
        cmd(0, 1, 0); hg_low = 0; sw_low = 0;
        expect_at(3, 0, 0, "R4 no flags");
        expect_at(12, 0, 0, "R4 no flags stays off");
        step(13);
        sw_low = 1;
        expect_at(3, 0, 1, "R3 late switch node low");
        step(5);

        // R10: redirect during rising dead time.
        cmd(1, 0, 0); lg_low = 0;
        expect_at(3, 0, 0, "R10 rising wait");
        step(6);
        cmd(0, 1, 0);
        expect_at(2, 0, 0, "R10 still waiting");
        expect_at(3, 0, 1, "R10 back to low side");
        step(5);

        // R10: redirect during falling dead time.
        lg_low = 1;
        cmd(1, 0, 0);
        expect_at(6, 1, 0, "R10 setup high");
        step(8);
        cmd(0, 1, 0); sw_low = 0; hg_low = 0;
        expect_at(3, 0, 0, "R10 falling wait");
        step(6);
        cmd(1, 0, 0);
        expect_at(2, 0, 0, "R10 falling wait held");
        expect_at(5, 0, 0, "R10 blank on redirect");
        expect_at(6, 1, 0, "R10 back to high side");
        step(8);

        // R5: mid window from high side.
        cmd(0, 0, 1);
        expect_at(7, 1, 0, "R5 before holdoff");
        expect_at(8, 0, 0, "R5 shutdown");
        expect_at(14, 0, 0, "R5 shutdown held");
        step(15);

        // R6: release to low.
        cmd(0, 1, 0);
        expect_at(2, 0, 0, "R6 release latency");
        expect_at(3, 0, 1, "R6 release low");
        step(5);

        // R5: mid window from low side in continuous mode.
        cmd(0, 0, 1);
        expect_at(7, 0, 1, "R5 low side before holdoff");
        expect_at(8, 0, 0, "R5 low side shutdown");
        step(10);
        cmd(0, 1, 0);
        expect_at(3, 0, 1, "R6 release low again");
        step(20);

        // R7: zero crossing in light load after minimum on-time.
        light = 1; zc = 1;
        expect_at(2, 0, 1, "R7 latency");
        expect_at(3, 0, 0, "R7 zero crossing opens low side");
        expect_at(10, 0, 0, "R7 stays open");
        step(12);
        cmd(1, 0, 0); sw_low = 1;
        expect_at(6, 1, 0, "R7 high from emulation idle");
        step(8);
        cmd(0, 1, 0);
        expect_at(4, 0, 1, "R7 low side entry");
        expect_at(19, 0, 1, "R7 minimum on-time holds");
        expect_at(20, 0, 0, "R7 minimum on-time expiry");
        step(22);
        light = 0;
        expect_at(3, 0, 1, "R7 leaving light load");
        expect_at(10, 0, 1, "R7 zero crossing ignored in continuous mode");
        step(12);

        // R8: minimum on-time outlasts the holdoff.
        light = 1; zc = 0;
        step(4);
        cmd(1, 0, 0);
        expect_at(6, 1, 0, "R8 setup high");
        step(8);
        cmd(0, 1, 0);
        expect_at(4, 0, 1, "R8 low side entry");
        step(4);
        cmd(0, 0, 1);
        expect_at(8, 0, 1, "R8 holdoff expired, low held");
        expect_at(15, 0, 1, "R8 still held");
        expect_at(16, 0, 0, "R8 shutdown after minimum on-time");
        step(18);

        // R1: supply loss and recovery.
        cmd(1, 0, 0);
        expect_at(6, 1, 0, "R6 release high");
        step(8);
        por = 0;
        expect_at(2, 1, 0, "R1 por fall latency");
        expect_at(3, 0, 0, "R1 por fall off");
        expect_at(8, 0, 0, "R1 por held off");
        step(10);
        por = 1;
        expect_at(5, 0, 0, "R1 recovery dead time");
        expect_at(6, 1, 0, "R1 recovery high");
        step(10);

        checks++;
        if (overlap != 0) begin
            errors++;
            $display("FAIL R9: got %0d overlap cycles, expected 0", overlap);
        end
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d pending items, expected 0", q.size());
        end
        done = 1;
        summary();
        $finish;
    end

endmodule